// File: doc/BRIEF.md
# Power-Management Event Status and Enable Registers

This block holds a 16-bit event status register, a 16-bit event enable register and a 16-bit control word. Software reaches all three through a small register port. Hardware events set status bits: a PM timer that reports its overflow time was reached, a power-button press, and a resume-from-sleep indication. Software clears a status bit by writing a one to it. A level-sensitive system control interrupt (`sci`) is raised whenever an enabled status bit in a fixed subset is set.

The block also works with an external free-running PM timer, which is not part of it. `tmr_arm` tells the timer when its overflow event should be scheduled. `tmr_recalc` asks the timer to compute a new overflow time after software acknowledges an overflow. The overflow input is folded into the status value on the same cycle it is seen, so a read issued in that cycle already shows it.

Top module: `pm1_evt_regs`

## Requirements
- R1: The port decodes 4-bit byte offsets 0x0 (status), 0x2 (enable) and 0x4 (control). While `bus_en`=1 and `bus_we`=0, `bus_rdata` returns the addressed register in the same cycle. Any other offset, or no read, returns 0. A write to the control offset stores all 16 bits.
- R2: A write to offset 0x0 clears each status bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R3: `sci` is 1 exactly when (status AND enable) has a 1 in bit 10, 8, 5 or 0. No other bit ever raises it.
- R4: While `tmr_ovf`=1, status bit 0 reads as 1 in that same cycle, and it remains set after `tmr_ovf` falls, until software clears it.
- R5: A status write with data bit 0 = 1, issued while status bit 0 is 1, produces a one-cycle `tmr_recalc` pulse in the cycle after the write. Such a write while bit 0 is 0 produces no pulse.
- R6: `tmr_arm` is 1 exactly when enable bit 0 is 1 and status bit 0 is 0.
- R7: A `pwrbtn_evt` cycle sets status bit 8 only if enable bit 8 is already 1. Otherwise the status register is unchanged.
- R8: A `resume_evt` cycle sets status bit 15 (wake) and status bit 8 (power button), whatever the enable bits are.
- R9: While `rst`=1, status, enable and control all become 0 at the clock edge.
- R10: A write to offset 0x2 replaces all 16 enable bits, and `sci` reflects the new enable value from the next cycle.
- R11: When a hardware event sets a bit in the same cycle that software writes 1 to clear it, the bit ends up set.
- R12: Reads change no register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| tmr_ovf | input | 1 | Timer overflow time reached (level) |
| pwrbtn_evt | input | 1 | Power-button press, one cycle per press |
| resume_evt | input | 1 | Resume from sleep, one cycle |
| sci | output | 1 | System control interrupt level |
| tmr_arm | output | 1 | Timer overflow event should be scheduled |
| tmr_recalc | output | 1 | One-cycle request to compute a new overflow time |

## Verification
The embedded properties assume that the event inputs are clean, synchronous one-cycle pulses, or a level in the case of `tmr_ovf`. They also assume that `bus_we` is only meaningful while `bus_en` is high. The stimulus changes every input only at the falling edge, and it asserts `resume_evt` and `pwrbtn_evt` in separate cycles, except for one cycle where the overlap is deliberate. It also drives one collision of `tmr_ovf` with a clearing write to exercise the case where the set wins. A behavioural reference model is advanced on every rising edge and compared with all outputs in the middle of each cycle.

// File: rtl/pm1_pkg.sv
package pm1_pkg;

    parameter int DW = 16;
    parameter int AW = 4;

    localparam logic [AW-1:0] OFF_STS = AW'(0);
    localparam logic [AW-1:0] OFF_EN  = AW'(2);
    localparam logic [AW-1:0] OFF_CTL = AW'(4);

    localparam int B_TMR  = 0;
    localparam int B_GBL  = 5;
    localparam int B_PWR  = 8;
    localparam int B_RTC  = 10;
    localparam int B_WAKE = 15;

    localparam logic [DW-1:0] SCI_MASK =
        (DW'(1) << B_RTC) | (DW'(1) << B_PWR) | (DW'(1) << B_GBL) | (DW'(1) << B_TMR);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STS,
        SEL_EN,
        SEL_CTL
    } reg_sel_e;

    typedef struct packed {
        logic          en;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic tmr_ovf;
        logic pwrbtn;
        logic resume;
    } hw_evt_t;

    function automatic reg_sel_e decode(input logic [AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_STS: s = SEL_STS;
            OFF_EN:  s = SEL_EN;
            OFF_CTL: s = SEL_CTL;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pm1_status_reg.sv
module pm1_status_reg
    import pm1_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_sts,
    input  logic [DW-1:0] wdata,
    input  hw_evt_t       evt,
    input  logic          pwr_enabled,
    output logic [DW-1:0] sts_eff,
    output logic          recalc
);

    logic [DW-1:0] sts_q;
    logic [DW-1:0] set_vec;
    logic [DW-1:0] clr_vec;
    logic          recalc_q;

    always_comb begin
        sts_eff = sts_q;
        sts_eff[B_TMR] = sts_q[B_TMR] | evt.tmr_ovf;
    end

    always_comb begin
        set_vec = '0;
        set_vec[B_TMR] = evt.tmr_ovf;
        set_vec[B_PWR] = (evt.pwrbtn & pwr_enabled) | evt.resume;
        set_vec[B_WAKE] = evt.resume;
        clr_vec = wr_sts ? wdata : '0;
    end

    for (genvar i = 0; i < DW; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) sts_q[i] <= 1'b0;
            else     sts_q[i] <= (sts_eff[i] & ~clr_vec[i]) | set_vec[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) recalc_q <= 1'b0;
        else     recalc_q <= wr_sts & wdata[B_TMR] & sts_eff[B_TMR];
    end

    assign recalc = recalc_q;

    // R2
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && wdata[B_WAKE] && !evt.resume) |=> !sts_q[B_WAKE]);

    // R7
    pwr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.pwrbtn && !pwr_enabled && !evt.resume && !sts_q[B_PWR]) |=> !sts_q[B_PWR]);

    // R8
    resume_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt.resume |=> (sts_q[B_WAKE] && sts_q[B_PWR]));

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        evt.tmr_ovf |=> sts_q[B_TMR]);

endmodule

// File: rtl/pm1_enable_ctrl.sv
module pm1_enable_ctrl
    import pm1_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] ctl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_en)  en_q  <= wdata;
            if (wr_ctl) ctl_q <= wdata;
        end
    end

    // R9
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0 && ctl_q == '0));

    // R10
    en_replace_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (en_q == $past(wdata)));

endmodule

// File: rtl/pm1_sci_gen.sv
module pm1_sci_gen
    import pm1_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] sts_eff,
    input  logic [DW-1:0] en_q,
    output logic          sci,
    output logic          tmr_arm
);

    logic [DW-1:0] hit;

    for (genvar i = 0; i < DW; i++) begin : g_hit
        if (SCI_MASK[i]) begin : g_src
            assign hit[i] = sts_eff[i] & en_q[i];
        end else begin : g_off
            assign hit[i] = 1'b0;
        end
    end

    assign sci     = |hit;
    assign tmr_arm = en_q[B_TMR] & ~sts_eff[B_TMR];

    // R3
    sci_src_chk: assert property (@(posedge clk) disable iff (rst)
        sci |-> ((en_q & SCI_MASK) != '0));

    // R6
    arm_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_arm |-> !sci || ((en_q & SCI_MASK & ~(DW'(1) << B_TMR)) != '0));

endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
    import pm1_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tmr_ovf,
    input  logic          pwrbtn_evt,
    input  logic          resume_evt,
    output logic          sci,
    output logic          tmr_arm,
    output logic          tmr_recalc
);

    bus_req_t      req;
    hw_evt_t       evt;
    reg_sel_e      sel;
    logic          wr;
    logic [DW-1:0] sts_eff;
    logic [DW-1:0] en_q;
    logic [DW-1:0] ctl_q;

    assign req = '{en: bus_en, we: bus_we, addr: bus_addr, wdata: bus_wdata};
    assign evt = '{tmr_ovf: tmr_ovf, pwrbtn: pwrbtn_evt, resume: resume_evt};
    assign sel = decode(req.addr);
    assign wr  = req.en & req.we;

    pm1_status_reg u_sts (
        .clk         (clk),
        .rst         (rst),
        .wr_sts      (wr && sel == SEL_STS),
        .wdata       (req.wdata),
        .evt         (evt),
        .pwr_enabled (en_q[B_PWR]),
        .sts_eff     (sts_eff),
        .recalc      (tmr_recalc)
    );

    pm1_enable_ctrl u_en (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr && sel == SEL_EN),
        .wr_ctl (wr && sel == SEL_CTL),
        .wdata  (req.wdata),
        .en_q   (en_q),
        .ctl_q  (ctl_q)
    );

    pm1_sci_gen u_sci (
        .clk     (clk),
        .rst     (rst),
        .sts_eff (sts_eff),
        .en_q    (en_q),
        .sci     (sci),
        .tmr_arm (tmr_arm)
    );

    always_comb begin
        bus_rdata = '0;
        if (req.en && !req.we) begin
            case (sel)
                SEL_STS: bus_rdata = sts_eff;
                SEL_EN:  bus_rdata = en_q;
                SEL_CTL: bus_rdata = ctl_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    // R5
    recalc_src_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_recalc |-> $past(bus_en && bus_we && bus_addr == OFF_STS && bus_wdata[B_TMR]));

    // R1
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && sel == SEL_NONE) |-> (bus_rdata == '0));

    // R4
    ovf_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_ovf && bus_en && !bus_we && bus_addr == OFF_STS) |-> bus_rdata[B_TMR]);

endmodule

// File: tb/tb_pm1_evt_regs.sv
`timescale 1ns/1ps
module tb_pm1_evt_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tmr_ovf = 1'b0, pwrbtn_evt = 1'b0, resume_evt = 1'b0;
    logic        sci, tmr_arm, tmr_recalc;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    logic [15:0] m_sts = '0, m_en = '0, m_ctl = '0;
    logic        m_recalc = 1'b0;

    always #2.5 clk = ~clk;

    pm1_evt_regs dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_ovf(tmr_ovf), .pwrbtn_evt(pwrbtn_evt), .resume_evt(resume_evt),
        .sci(sci), .tmr_arm(tmr_arm), .tmr_recalc(tmr_recalc)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic r, input logic en, input logic we,
                        input logic [3:0] a, input logic [15:0] wd,
                        input logic ovf, input logic pwr, input logic res);
        logic [15:0] eff, exp_rd, clr, setv;
        @(negedge clk);
        rst = r; bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd;
        tmr_ovf = ovf; pwrbtn_evt = pwr; resume_evt = res;
        #1;
        eff = m_sts | {15'd0, ovf};
        exp_rd = 16'h0;
        if (en && !we) begin
            if (a == 4'h0) exp_rd = eff;
            else if (a == 4'h2) exp_rd = m_en;
            else if (a == 4'h4) exp_rd = m_ctl;
        end
        if (!r) begin
            chk(tag, "rdata", bus_rdata, exp_rd);
            chk("R3", "sci", {15'd0, sci}, {15'd0, ((eff & m_en & 16'h0521) != 0)});
            chk("R6", "arm", {15'd0, tmr_arm}, {15'd0, (m_en[0] && !eff[0])});
            chk("R5", "recalc", {15'd0, tmr_recalc}, {15'd0, m_recalc});
        end
        @(posedge clk);
        if (r) begin
            m_sts = 0; m_en = 0; m_ctl = 0; m_recalc = 0;
        end else begin
            clr = (en && we && a == 4'h0) ? wd : 16'h0;
            setv = {15'd0, ovf};
            if (pwr && m_en[8]) setv = setv | 16'h0100;
            if (res) setv = setv | 16'h8100;
            m_recalc = en && we && a == 4'h0 && wd[0] && eff[0];
            m_sts = (eff & ~clr) | setv;
            if (en && we && a == 4'h2) m_en = wd;
            if (en && we && a == 4'h4) m_ctl = wd;
        end
    endtask

    task automatic rd(input string tag, input logic [3:0] a);
        step(tag, 0, 1, 0, a, 16'h0, 0, 0, 0);
    endtask
    task automatic wr(input string tag, input logic [3:0] a, input logic [15:0] d);
        step(tag, 0, 1, 1, a, d, 0, 0, 0);
    endtask
    task automatic evt(input string tag, input logic ovf, input logic pwr, input logic res);
        step(tag, 0, 1, 0, 4'h0, 16'h0, ovf, pwr, res);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                tests++; fails++;
                $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        // R9 reset state
        step("R9", 1, 0, 0, 4'h0, 16'h0, 0, 0, 0);
        step("R9", 1, 0, 0, 4'h0, 16'h0, 0, 0, 0);
        rd("R9", 4'h0); rd("R9", 4'h2); rd("R9", 4'h4);
        // R10 full replace of enable, R7 gated press
        wr("R10", 4'h2, 16'h0100);
        rd("R10", 4'h2);
        evt("R7", 0, 1, 0);
        rd("R7", 4'h0);
        // R2 write one to clear
        wr("R2", 4'h0, 16'h0100);
        rd("R2", 4'h0);
        // R7 press ignored while disabled
        wr("R10", 4'h2, 16'h0000);
        evt("R7", 0, 1, 0);
        rd("R7", 4'h0);
        // R8 resume sets wake and button
        evt("R8", 0, 0, 1);
        rd("R8", 4'h0);
        wr("R3", 4'h2, 16'h8000);
        rd("R3", 4'h0);
        wr("R10", 4'h2, 16'h0100);
        rd("R10", 4'h0);
        wr("R2", 4'h0, 16'h8000);
        rd("R2", 4'h0);
        wr("R2", 4'h0, 16'hFFFF);
        // R6 arm, R4 overflow visible at once
        wr("R6", 4'h2, 16'h0001);
        rd("R6", 4'h0);
        evt("R4", 1, 0, 0);
        rd("R4", 4'h0);
        wr("R5", 4'h0, 16'h0001);
        rd("R5", 4'h0);
        wr("R5", 4'h0, 16'h0001);
        rd("R5", 4'h0);
        // R11 set wins over clear
        step("R11", 0, 1, 1, 4'h0, 16'h0001, 1, 0, 0);
        rd("R11", 4'h0);
        wr("R11", 4'h0, 16'h0001);
        rd("R11", 4'h0);
        // R3 masked bits: all enables, only wake pending -> no sci
        wr("R3", 4'h2, 16'hFFFF);
        evt("R3", 0, 0, 1);
        wr("R3", 4'h0, 16'h0100);
        rd("R3", 4'h0);
        // R1 control and unmapped
        wr("R1", 4'h4, 16'hA5A5);
        rd("R1", 4'h4);
        rd("R1", 4'h6);
        rd("R1", 4'h1);
        step("R1", 0, 0, 0, 4'h4, 16'h0, 0, 0, 0);
        // R12 repeated reads
        rd("R12", 4'h0); rd("R12", 4'h0); rd("R12", 4'h2); rd("R12", 4'h4);
        // R8 with R7 overlap, then R9 mid-run reset
        wr("R7", 4'h2, 16'h0000);
        evt("R8", 0, 1, 1);
        rd("R8", 4'h0);
        step("R9", 1, 0, 0, 4'h0, 16'h0, 0, 0, 0);
        rd("R9", 4'h0); rd("R9", 4'h2); rd("R9", 4'h4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule